// File: doc/BRIEF.md
# Gated Seven-Decade Event Counter with Latched Scanned Display

This block counts rising edges of an event input while a gate level is high. It keeps the running total as seven BCD decades, so a frequency or period meter can read it directly. The first decade rolls from 9 to 0 and sends a carry to the decade above it. A carry out of the top decade sets a sticky overflow bit.

A transfer strobe copies the running total and the overflow bit into holding registers. The display side reads only these holding registers, so a new count can run while the last result stays on view. A separate counter-clear input zeroes the running total and the overflow bit and leaves the held result alone.

The held result is scanned out on two BCD lanes at the same time, and each lane has its own digit-address output. The upper lane shows the four upper decades. The lower lane shows the three lower decades and drops its valid flag on the spare scan slot. The event input may be asynchronous: it passes through a synchronizer and an edge detector.

Top module: `gated_decade_counter`

## Requirements
- R1: An event edge changes the running count only when gate_i is high in the cycle where the edge is detected. Edges while gate_i is low leave the count unchanged, and the next transfer shows this.
- R2: Each rising edge of count_i adds exactly one, however long count_i stays high.
- R3: Each decade holds a BCD value from 0 to 9. A step at 9 returns that decade to 0 and steps the decade above it.
- R4: A transfer_i pulse copies all seven decades into the holding registers. The scanned value does not change in any cycle without transfer_i.
- R5: When transfer_i and a detected event edge fall in the same cycle, the held value is the count before that edge. The edge is still counted.
- R6: A carry out of the most significant decade wraps the count to zero and sets a sticky overflow bit. That bit stays set until count_clr_i or reset.
- R7: ovf_disp_o takes the sticky overflow bit only on transfer_i. An overflow after a transfer does not change ovf_disp_o until the next transfer.
- R8: count_clr_i zeroes the running count and the sticky overflow bit. It leaves the held digits and ovf_disp_o unchanged.
- R9: After rst_ni the count, the held digits and ovf_disp_o are all zero.
- R10: Both lanes share one scan position p, which is driven on lo_addr_o and hi_addr_o. hi_bcd_o carries held decade 3+p for p = 0..3. For p = 0..2, lo_bcd_o carries held decade p and lo_valid_o is 1. At p = 3, lo_valid_o is 0 and lo_bcd_o is 0.
- R11: The scan position holds for SCAN_DIV clock cycles, then steps by one, wrapping from 3 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| count_i | input | 1 | Event input; may be asynchronous |
| gate_i | input | 1 | Counting window, active high, synchronous to clk_i |
| transfer_i | input | 1 | Copies count and overflow into the display registers |
| count_clr_i | input | 1 | Synchronous clear of running count and sticky overflow |
| lo_bcd_o | output | 4 | BCD digit of the lower lane |
| lo_addr_o | output | 2 | Digit address of the lower lane |
| lo_valid_o | output | 1 | High while the lower lane holds a digit |
| hi_bcd_o | output | 4 | BCD digit of the upper lane |
| hi_addr_o | output | 2 | Digit address of the upper lane |
| ovf_disp_o | output | 1 | Overflow indicator that goes with the held value |

## Verification
The assertions check the cycle-level rules in every cycle:
- a decade never leaves 0..9 and steps or wraps correctly;
- the edge detector never fires two cycles in a row;
- the count is frozen while the gate is low;
- the clear empties the count and the overflow bit;
- the sticky overflow bit persists;
- the holding registers move only on transfer;
- the scan position advances only by one or wraps.

Only the bench scenarios can show the end-to-end results: totals of many pulses with carries across several decades, a long high level counted once, the pre-edge value captured when a transfer and an edge share a cycle, and the overflow showing up one transfer late. A second, narrower instance reaches a real top-decade carry in a few thousand cycles.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;
  typedef logic [3:0] bcd_t;
  localparam bcd_t BCD_TOP = 4'd9;
  localparam bcd_t BCD_ZERO = 4'd0;
endpackage

// File: rtl/dcnt_rst_sync.sv
module dcnt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_sync_no = chain_q[STAGES-1];
endmodule

// File: rtl/dcnt_edge_sync.sv
module dcnt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;
  logic              prev_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], level_i};
    prev_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  // R2: a single input edge can never yield two consecutive steps
  assert_one_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/dcnt_decade.sv
module dcnt_decade
  import dcnt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  output bcd_t digit_o,
  output logic carry_o
);
  bcd_t digit_q;
  bcd_t digit_d;
  logic wrap;

  always_comb begin
    wrap    = (digit_q == BCD_TOP);
    digit_d = digit_q;
    if (clr_i)       digit_d = BCD_ZERO;
    else if (step_i) digit_d = wrap ? BCD_ZERO : digit_q + 4'd1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) digit_q <= BCD_ZERO;
    else         digit_q <= digit_d;
  end

  assign digit_o = digit_q;
  assign carry_o = step_i & wrap & ~clr_i;

  assert_digit_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    digit_q <= BCD_TOP);
  assert_digit_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clr_i && digit_q == BCD_TOP) |=> digit_q == BCD_ZERO);
  assert_digit_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clr_i && digit_q != BCD_TOP) |=> digit_q == $past(digit_q) + 4'd1);
endmodule

// File: rtl/dcnt_scan.sv
module dcnt_scan
  import dcnt_pkg::*;
#(
  parameter int DIGITS_LO = 3,
  parameter int DIGITS_HI = 4,
  parameter int SCAN_DIV  = 4,
  localparam int NUM_DIG  = DIGITS_LO + DIGITS_HI,
  localparam int POS_W    = (DIGITS_HI > 1) ? $clog2(DIGITS_HI) : 1,
  localparam int PRE_W    = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  bcd_t [NUM_DIG-1:0]   held_i,
  output bcd_t                 lo_bcd_o,
  output logic [POS_W-1:0]     lo_addr_o,
  output logic                 lo_valid_o,
  output bcd_t                 hi_bcd_o,
  output logic [POS_W-1:0]     hi_addr_o
);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(SCAN_DIV - 1);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(DIGITS_HI - 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic             tick;

  always_comb begin
    tick  = (pre_q == PRE_LAST);
    pre_d = tick ? '0 : pre_q + 1'b1;
    pos_d = pos_q;
    if (tick) pos_d = (pos_q == POS_LAST) ? '0 : pos_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      pos_q <= '0;
    end else begin
      pre_q <= pre_d;
      pos_q <= pos_d;
    end
  end

  always_comb begin
    hi_bcd_o   = BCD_ZERO;
    lo_bcd_o   = BCD_ZERO;
    lo_valid_o = 1'b0;
    for (int i = 0; i < DIGITS_HI; i++) begin
      if (pos_q == POS_W'(i)) hi_bcd_o = held_i[DIGITS_LO + i];
    end
    for (int j = 0; j < DIGITS_LO; j++) begin
      if (pos_q == POS_W'(j)) begin
        lo_bcd_o   = held_i[j];
        lo_valid_o = 1'b1;
      end
    end
  end

  assign lo_addr_o = pos_q;
  assign hi_addr_o = pos_q;

  assert_scan_step_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pos_q) |-> (pos_q == '0 || pos_q == $past(pos_q) + 1'b1));
  assert_scan_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q <= POS_LAST);
endmodule

// File: rtl/gated_decade_counter.sv
module gated_decade_counter
  import dcnt_pkg::*;
#(
  parameter int DIGITS_LO   = 3,
  parameter int DIGITS_HI   = 4,
  parameter int SCAN_DIV    = 4,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = (DIGITS_HI > 1) ? $clog2(DIGITS_HI) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              count_i,
  input  logic              gate_i,
  input  logic              transfer_i,
  input  logic              count_clr_i,
  output logic [3:0]        lo_bcd_o,
  output logic [ADDR_W-1:0] lo_addr_o,
  output logic              lo_valid_o,
  output logic [3:0]        hi_bcd_o,
  output logic [ADDR_W-1:0] hi_addr_o,
  output logic              ovf_disp_o
);
  localparam int NUM_DIG = DIGITS_LO + DIGITS_HI;

  logic               rst_n;
  logic               rise;
  logic               inc;
  logic [NUM_DIG:0]   step;
  bcd_t [NUM_DIG-1:0] cnt_w;
  bcd_t [NUM_DIG-1:0] held_q, held_d;
  logic               ovf_q, ovf_d;
  logic               ovf_disp_q, ovf_disp_d;

  dcnt_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n)
  );

  dcnt_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .level_i (count_i),
    .rise_o  (rise)
  );

  assign inc     = rise & gate_i;
  assign step[0] = inc;

  for (genvar g = 0; g < NUM_DIG; g++) begin : g_decade
    dcnt_decade u_dec (
      .clk_i   (clk_i),
      .rst_ni  (rst_n),
      .clr_i   (count_clr_i),
      .step_i  (step[g]),
      .digit_o (cnt_w[g]),
      .carry_o (step[g+1])
    );
  end

  always_comb begin
    ovf_d = ovf_q;
    if (count_clr_i)        ovf_d = 1'b0;
    else if (step[NUM_DIG]) ovf_d = 1'b1;
    held_d     = held_q;
    ovf_disp_d = ovf_disp_q;
    if (transfer_i) begin
      held_d     = cnt_w;
      ovf_disp_d = ovf_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q      <= 1'b0;
      held_q     <= '0;
      ovf_disp_q <= 1'b0;
    end else begin
      ovf_q      <= ovf_d;
      held_q     <= held_d;
      ovf_disp_q <= ovf_disp_d;
    end
  end

  dcnt_scan #(
    .DIGITS_LO (DIGITS_LO),
    .DIGITS_HI (DIGITS_HI),
    .SCAN_DIV  (SCAN_DIV)
  ) u_scan (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .held_i     (held_q),
    .lo_bcd_o   (lo_bcd_o),
    .lo_addr_o  (lo_addr_o),
    .lo_valid_o (lo_valid_o),
    .hi_bcd_o   (hi_bcd_o),
    .hi_addr_o  (hi_addr_o)
  );

  assign ovf_disp_o = ovf_disp_q;

  assert_gate_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!gate_i && !count_clr_i) |=> $stable(cnt_w));
  assert_ovf_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (ovf_q && !count_clr_i) |=> ovf_q);
  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    count_clr_i |=> (cnt_w == '0 && !ovf_q));
  assert_held_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    !transfer_i |=> $stable(held_q));
  assert_ovf_disp_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    !transfer_i |=> $stable(ovf_disp_q));
endmodule

// File: tb/gated_decade_counter_tb.sv
`timescale 1ns/1ps
module gated_decade_counter_tb;
  localparam int LO = 3, HI = 4, DIV = 4, SYNC = 2;
  localparam int S_LO = 1, S_HI = 2, S_DIV = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic cnt_in = 1'b0, gate = 1'b0, xfer = 1'b0, clr = 1'b0;
  logic [3:0] lo_bcd, hi_bcd;
  logic [1:0] lo_addr, hi_addr;
  logic lo_valid, ovf_disp;

  logic s_cnt = 1'b0, s_xfer = 1'b0, s_clr = 1'b0;
  logic [3:0] s_lo_bcd, s_hi_bcd;
  logic s_lo_addr, s_hi_addr, s_lo_valid, s_ovf;

  gated_decade_counter #(.DIGITS_LO(LO), .DIGITS_HI(HI), .SCAN_DIV(DIV), .SYNC_STAGES(SYNC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .count_i(cnt_in), .gate_i(gate), .transfer_i(xfer),
    .count_clr_i(clr), .lo_bcd_o(lo_bcd), .lo_addr_o(lo_addr), .lo_valid_o(lo_valid),
    .hi_bcd_o(hi_bcd), .hi_addr_o(hi_addr), .ovf_disp_o(ovf_disp));

  gated_decade_counter #(.DIGITS_LO(S_LO), .DIGITS_HI(S_HI), .SCAN_DIV(S_DIV), .SYNC_STAGES(SYNC)) u_small (
    .clk_i(clk), .rst_ni(rst_n), .count_i(s_cnt), .gate_i(1'b1), .transfer_i(s_xfer),
    .count_clr_i(s_clr), .lo_bcd_o(s_lo_bcd), .lo_addr_o(s_lo_addr), .lo_valid_o(s_lo_valid),
    .hi_bcd_o(s_hi_bcd), .hi_addr_o(s_hi_addr), .ovf_disp_o(s_ovf));

  int n_chk = 0, n_fail = 0;
  int model = 0;

  typedef struct { int value; bit ovf; string tag; } exp_t;
  exp_t sb_q[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // driver side: push an expectation and wait for the monitor to consume it
  task automatic expect_disp(input int v, input bit o, input string tag);
    exp_t e;
    e.value = v; e.ovf = o; e.tag = tag;
    sb_q.push_back(e);
    wait (sb_q.size() == 0);
  endtask

  // monitor: scan a full display cycle and compare with the queue head
  initial begin
    forever begin
      exp_t e;
      int got[LO+HI];
      int v;
      bit lane_ok;
      wait (sb_q.size() > 0);
      e = sb_q[0];
      lane_ok = 1'b1;
      for (int i = 0; i < LO+HI; i++) got[i] = -1;
      for (int k = 0; k < HI*DIV; k++) begin
        @(negedge clk);
        got[LO + int'(hi_addr)] = int'(hi_bcd);
        if (lo_valid) begin
          if (int'(lo_addr) < LO) got[lo_addr] = int'(lo_bcd);
          else lane_ok = 1'b0;
        end else if (int'(lo_addr) < LO || lo_bcd != 4'd0) lane_ok = 1'b0;
      end
      v = 0;
      for (int i = 0; i < LO+HI; i++) begin
        if (got[i] < 0 || v < 0) v = -1;
        else v = v + got[i] * (10 ** i);
      end
      check(v == e.value, {e.tag, " value"}, v, e.value);
      check(ovf_disp == e.ovf, {e.tag, " ovf"}, int'(ovf_disp), int'(e.ovf));
      check(lane_ok, {e.tag, " R10 lane valid/addr"}, int'(lane_ok), 1);
      void'(sb_q.pop_front());
    end
  end

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cnt_in = 1'b1;
      repeat (2) @(negedge clk);
      cnt_in = 1'b0;
      repeat (2) @(negedge clk);
      if (gate) model = (model + 1) % 10000000;
    end
  endtask

  task automatic transfer();
    @(negedge clk); xfer = 1'b1;
    @(negedge clk); xfer = 1'b0;
  endtask

  task automatic s_pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); s_cnt = 1'b1;
      repeat (2) @(negedge clk);
      s_cnt = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic s_transfer();
    @(negedge clk); s_xfer = 1'b1;
    @(negedge clk); s_xfer = 1'b0;
  endtask

  task automatic s_expect(input int ev, input bit eo, input string tag);
    int d[3];
    int v;
    for (int i = 0; i < 3; i++) d[i] = -1;
    for (int k = 0; k < S_HI*S_DIV; k++) begin
      @(negedge clk);
      d[S_LO + int'(s_hi_addr)] = int'(s_hi_bcd);
      if (s_lo_valid) d[0] = int'(s_lo_bcd);
    end
    v = (d[0] < 0 || d[1] < 0 || d[2] < 0) ? -1 : d[0] + 10*d[1] + 100*d[2];
    check(v == ev, {tag, " value"}, v, ev);
    check(s_ovf == eo, {tag, " ovf"}, int'(s_ovf), int'(eo));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    expect_disp(0, 1'b0, "R9 reset state");

    gate = 1'b1;
    pulse(7);
    expect_disp(0, 1'b0, "R4 held before transfer");
    transfer();
    expect_disp(7, 1'b0, "R4 after transfer");

    @(negedge clk); clr = 1'b1; @(negedge clk); clr = 1'b0;
    model = 0;
    expect_disp(7, 1'b0, "R8 display kept over clear");
    transfer();
    expect_disp(0, 1'b0, "R8 count cleared");

    pulse(1005);
    transfer();
    expect_disp(model, 1'b0, "R3 decade carries");

    @(negedge clk); gate = 1'b0;
    pulse(50);
    @(negedge clk); gate = 1'b1;
    transfer();
    expect_disp(1005, 1'b0, "R1 gate low ignored");

    @(negedge clk); cnt_in = 1'b1;
    repeat (20) @(negedge clk);
    cnt_in = 1'b0;
    repeat (3) @(negedge clk);
    model = model + 1;
    transfer();
    expect_disp(1006, 1'b0, "R2 long level counts once");

    pulse(94);
    // edge detected in the same cycle as the transfer strobe
    @(negedge clk); cnt_in = 1'b1;
    repeat (SYNC) @(negedge clk);
    xfer = 1'b1;
    @(negedge clk); xfer = 1'b0; cnt_in = 1'b0;
    repeat (3) @(negedge clk);
    expect_disp(1100, 1'b0, "R5 pre-edge value captured");
    transfer();
    expect_disp(1101, 1'b0, "R5 edge still counted");

    begin : scan_rate
      logic [1:0] a0, a1;
      int n;
      @(negedge clk); a0 = hi_addr;
      while (hi_addr == a0) @(negedge clk);
      a1 = hi_addr; n = 0;
      while (hi_addr == a1) begin @(negedge clk); n++; end
      check(n == DIV, "R11 scan dwell", n, DIV);
      check(int'(hi_addr) == (int'(a1) + 1) % HI, "R11 scan order", int'(hi_addr), (int'(a1) + 1) % HI);
    end

    s_pulse(999);
    s_transfer();
    s_expect(999, 1'b0, "R6 small top value");
    s_pulse(1);
    repeat (3) @(negedge clk);
    s_expect(999, 1'b0, "R7 overflow not shown before transfer");
    s_transfer();
    s_expect(0, 1'b1, "R6 wrap sets overflow");
    s_pulse(5);
    s_transfer();
    s_expect(5, 1'b1, "R6 overflow sticky");
    @(negedge clk); s_clr = 1'b1; @(negedge clk); s_clr = 1'b0;
    s_expect(5, 1'b1, "R7 indicator kept over clear");
    s_transfer();
    s_expect(0, 1'b0, "R8 clear drops overflow");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule